// File: doc/BRIEF.md
# Four-Byte Batch Echo Buffer

This block sits between a serial receiver and a serial transmitter and returns received bytes in batches. Each byte strobe from the receiver writes one byte into on-chip storage. When the fourth byte of a batch has been written, the block plays the batch back to the transmitter: a one-cycle start strobe carries each byte, and the next byte waits for the transmitter's completion pulse. An incomplete batch stays in storage until its fourth byte arrives.

The store has separate read and write ports, so the receive path keeps writing while a batch is being played back. A store that shares one port between reads and writes loses bytes when a burst is not 1, 2 or 4 bytes long; this design does not. The store holds two batches. A batch is accepted or refused as a whole when its first byte arrives. It is refused when two complete batches are already waiting or in playback, and the refusal sets a sticky overflow flag. Unsent data is never overwritten.

Top module: `batch_echo_buffer`

## Requirements
- R1: While rst_ni is low, and at once when it falls, tx_start_o, tx_data_o and overflow_o are 0. After reset the batch fill position and the read and write positions are back at the start of storage.
- R2: A batch with fewer than four stored bytes is never sent. tx_start_o stays low while no complete batch is pending.
- R3: The bytes of a batch go out in the order they were received. Batches go out in the order they were completed.
- R4: Suppose no batch is in playback and the fourth byte of a batch is sampled at rising edge k. Then tx_start_o is high for the cycle after edge k+1, and tx_data_o holds the first byte of that batch.
- R5: tx_start_o is a one-cycle pulse. tx_data_o stays unchanged from that pulse until tx_done_i is sampled. The edge that samples tx_done_i raises tx_start_o with the next byte of the batch. A tx_done_i that arrives in the same cycle as the start pulse is ignored.
- R6: Bytes keep being accepted while a batch is played back. No byte is lost, whatever the burst length, as long as fewer than two complete batches are pending when a new batch begins.
- R7: A byte strobe and a tx_done_i in the same cycle both take effect in that cycle. The byte is stored, and the next byte of the batch in playback is started.
- R8: Suppose the first byte of a batch arrives while two complete batches are pending or in playback. Then all four bytes of that batch are discarded, and overflow_o goes high one edge later and stays high until reset. The pending batches are sent unchanged. A batch that begins after space has been freed is accepted.
- R9: A tx_done_i that arrives while no byte is in playback has no effect. It neither starts a transmission nor advances the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is on rx_data_i |
| rx_data_i | input | DATA_W (8) | Received byte |
| tx_done_i | input | 1 | One-cycle pulse: the transmitter finished the current byte |
| tx_start_o | output | 1 | One-cycle strobe: start transmitting tx_data_o |
| tx_data_o | output | DATA_W (8) | Byte to transmit, held until tx_done_i |
| overflow_o | output | 1 | Sticky flag: a batch was discarded for lack of space |

## Verification
A wrong batch fill position shows at the ports either as a batch that starts one byte early or late, or as a rotated byte order. Either appears in the first tx_start_o after the fourth strobe, which is two edges later. A wrong occupancy count shows as a start strobe with no complete batch pending, or as overflow_o rising on a batch that should fit. The overflow case shows one edge after that batch's first byte. A read position that moves on a stray or early tx_done_i shows up as a skipped or repeated byte in the next batch played back. The directed scenarios are built to expose each of these.

// File: rtl/batch_echo_pkg.sv
package batch_echo_pkg;
  typedef enum logic {
    RD_IDLE,
    RD_BUSY
  } rd_state_e;
endpackage

// File: rtl/bee_store.sv
module bee_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // independent read port: reads never stall writes
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/bee_wr_ctrl.sv
module bee_wr_ctrl #(
  parameter int GROUP_LEN  = 4,
  parameter int NUM_GROUPS = 2,
  localparam int DEPTH  = GROUP_LEN * NUM_GROUPS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              slot_free_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              group_done_o,
  output logic              overflow_o
);
  logic [IDX_W-1:0] idx_q;
  logic [GRP_W-1:0] grp_q;
  logic             drop_q;
  logic             first, last, accept;

  assign first  = (idx_q == '0);
  assign last   = (idx_q == IDX_W'(GROUP_LEN - 1));
  // admission decided once per group, on its first byte
  assign accept = first ? slot_free_i : !drop_q;

  assign we_o         = rx_valid_i && accept;
  assign group_done_o = we_o && last;
  assign waddr_o      = ADDR_W'(grp_q) * ADDR_W'(GROUP_LEN) + ADDR_W'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      grp_q      <= '0;
      drop_q     <= 1'b0;
      overflow_o <= 1'b0;
    end else if (rx_valid_i) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      if (first) begin
        drop_q <= !slot_free_i;
        if (!slot_free_i) overflow_o <= 1'b1;
      end
      if (group_done_o)
        grp_q <= (grp_q == GRP_W'(NUM_GROUPS - 1)) ? '0 : grp_q + 1'b1;
    end
  end

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_ovf_on_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && first && !slot_free_i) |=> overflow_o);
endmodule

// File: rtl/bee_rd_ctrl.sv
module bee_rd_ctrl
  import batch_echo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int GROUP_LEN  = 4,
  parameter int NUM_GROUPS = 2,
  localparam int DEPTH  = GROUP_LEN * NUM_GROUPS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_avail_i,
  input  logic              tx_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              tx_start_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              group_sent_o
);
  rd_state_e        state_q;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic [GRP_W-1:0] grp_q;
  logic             last, done_ok;

  assign last    = (idx_q == IDX_W'(GROUP_LEN - 1));
  // a done coinciding with our own start strobe is not a completion
  assign done_ok = (state_q == RD_BUSY) && tx_done_i && !tx_start_o;
  assign nxt_idx = (state_q == RD_IDLE) ? '0 : idx_q + 1'b1;
  assign raddr_o = ADDR_W'(grp_q) * ADDR_W'(GROUP_LEN) + ADDR_W'(nxt_idx);
  assign group_sent_o = done_ok && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RD_IDLE;
      idx_q      <= '0;
      grp_q      <= '0;
      tx_start_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_start_o <= 1'b0;
      case (state_q)
        RD_IDLE: if (grp_avail_i) begin
          tx_start_o <= 1'b1;
          tx_data_o  <= rdata_i;
          idx_q      <= '0;
          state_q    <= RD_BUSY;
        end
        RD_BUSY: if (done_ok) begin
          if (last) begin
            state_q <= RD_IDLE;
            grp_q   <= (grp_q == GRP_W'(NUM_GROUPS - 1)) ? '0 : grp_q + 1'b1;
          end else begin
            idx_q      <= nxt_idx;
            tx_start_o <= 1'b1;
            tx_data_o  <= rdata_i;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  p_start_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  p_hold_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_BUSY && !tx_done_i) |=> ($stable(tx_data_o) && !tx_start_o));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_IDLE && !grp_avail_i) |=> !tx_start_o);
endmodule

// File: rtl/batch_echo_buffer.sv
module batch_echo_buffer #(
  parameter int DATA_W     = 8,
  parameter int GROUP_LEN  = 4,
  parameter int NUM_GROUPS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_done_i,
  output logic              tx_start_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              overflow_o
);
  localparam int DEPTH  = GROUP_LEN * NUM_GROUPS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int OCC_W  = $clog2(NUM_GROUPS + 1);

  logic              we, group_done, group_sent;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;
  logic [OCC_W-1:0]  occ_q;   // complete groups not yet fully sent
  logic              slot_free, grp_avail;

  assign slot_free = (occ_q < OCC_W'(NUM_GROUPS));
  assign grp_avail = (occ_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else begin
      case ({group_done, group_sent})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  bee_wr_ctrl #(.GROUP_LEN(GROUP_LEN), .NUM_GROUPS(NUM_GROUPS)) i_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .slot_free_i (slot_free),
    .we_o        (we),
    .waddr_o     (waddr),
    .group_done_o(group_done),
    .overflow_o  (overflow_o)
  );

  bee_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(rx_data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  bee_rd_ctrl #(.DATA_W(DATA_W), .GROUP_LEN(GROUP_LEN), .NUM_GROUPS(NUM_GROUPS)) i_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grp_avail_i (grp_avail),
    .tx_done_i   (tx_done_i),
    .rdata_i     (rdata),
    .raddr_o     (raddr),
    .tx_start_o  (tx_start_o),
    .tx_data_o   (tx_data_o),
    .group_sent_o(group_sent)
  );

  p_occ_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(NUM_GROUPS));

  p_sent_needs_group_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_sent |-> grp_avail);

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_start_o && !overflow_o && occ_q == '0));
endmodule

// File: tb/test_batch_echo_buffer.sv
module test_batch_echo_buffer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       tx_done_i = 1'b0;
  logic       tx_start_o;
  logic [7:0] tx_data_o;
  logic       overflow_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  auto_mode = 1'b0;
  int  tx_delay = 3;
  logic [7:0] got[$];

  always #5 clk = ~clk;

  batch_echo_buffer i_batch_echo_buffer (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .tx_done_i(tx_done_i), .tx_start_o(tx_start_o), .tx_data_o(tx_data_o),
    .overflow_o(overflow_o)
  );

  // record every issued byte
  initial forever begin
    @(negedge clk);
    if (tx_start_o) got.push_back(tx_data_o);
  end

  // transmitter model in auto mode
  initial forever begin
    @(negedge clk);
    while (auto_mode && tx_start_o) begin
      repeat (tx_delay) @(negedge clk);
      tx_done_i = 1'b1;
      @(negedge clk);
      tx_done_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_seq(input logic [7:0] exp[$], input string tag);
    chk(got.size() == exp.size(), {tag, " count"}, got.size(), exp.size());
    foreach (exp[i]) begin
      if (i < got.size())
        chk(got[i] == exp[i], {tag, " byte"}, got[i], exp[i]);
    end
  endtask

  task automatic do_reset(input bit auto_en);
    auto_mode = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0; rx_valid_i = 1'b0; tx_done_i = 1'b0; rx_data_i = '0;
    repeat (3) @(negedge clk);
    got.delete();
    rst_ni = 1'b1;
    auto_mode = auto_en;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic pulse_done();
    repeat (3) @(negedge clk);
    tx_done_i = 1'b1;
    @(negedge clk);
    tx_done_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(tx_start_o == 1'b0, "R1 start in reset", tx_start_o, 0);
    chk(tx_data_o == 8'h00, "R1 data in reset", tx_data_o, 0);
    chk(overflow_o == 1'b0, "R1 overflow in reset", overflow_o, 0);
  endtask

  task automatic t_partial();
    logic [7:0] e[$];
    do_reset(1'b1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    repeat (40) @(negedge clk);
    chk(got.size() == 0, "R2 partial group held", got.size(), 0);
    send_byte(8'h44);
    repeat (60) @(negedge clk);
    e = '{8'h11, 8'h22, 8'h33, 8'h44};
    chk_seq(e, "R3 order");
  endtask

  task automatic t_latency();
    logic [7:0] e[$];
    do_reset(1'b0);
    send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2);
    send_byte(8'hA3);
    chk(tx_start_o == 1'b0, "R4 no start one edge after", tx_start_o, 0);
    @(negedge clk);
    chk(tx_start_o == 1'b1, "R4 start two edges after", tx_start_o, 1);
    chk(tx_data_o == 8'hA0, "R4 first byte", tx_data_o, 8'hA0);
    @(negedge clk);
    chk(tx_start_o == 1'b0, "R5 single-cycle start", tx_start_o, 0);
    repeat (4) @(negedge clk);
    chk(tx_data_o == 8'hA0 && !tx_start_o, "R5 data held until done", tx_data_o, 8'hA0);
    tx_done_i = 1'b1;
    @(negedge clk);
    tx_done_i = 1'b0;
    chk(tx_start_o == 1'b1 && tx_data_o == 8'hA1, "R5 next byte after done", tx_data_o, 8'hA1);
    pulse_done(); pulse_done(); pulse_done();
    repeat (10) @(negedge clk);
    e = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
    chk_seq(e, "R3 latency run");
  endtask

  task automatic t_burst();
    logic [7:0] e[$];
    do_reset(1'b1);
    tx_delay = 20;
    for (int i = 0; i < 7; i++) begin
      send_byte(8'h50 + 8'(i));
      repeat (23) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    chk(got.size() == 4, "R6 only full group sent", got.size(), 4);
    send_byte(8'h57);
    repeat (150) @(negedge clk);
    for (int i = 0; i < 8; i++) e.push_back(8'h50 + 8'(i));
    chk_seq(e, "R6 burst of 7 plus 1");
    chk(overflow_o == 1'b0, "R6 no overflow", overflow_o, 0);
    tx_delay = 3;
  endtask

  task automatic t_same_cycle();
    logic [7:0] e[$];
    do_reset(1'b0);
    send_byte(8'hC0); send_byte(8'hC1); send_byte(8'hC2); send_byte(8'hC3);
    repeat (3) @(negedge clk);
    tx_done_i = 1'b1; rx_valid_i = 1'b1; rx_data_i = 8'hD0;
    @(negedge clk);
    tx_done_i = 1'b0; rx_valid_i = 1'b0;
    chk(tx_start_o == 1'b1 && tx_data_o == 8'hC1, "R7 done taken with strobe", tx_data_o, 8'hC1);
    pulse_done(); pulse_done(); pulse_done();
    send_byte(8'hD1); send_byte(8'hD2); send_byte(8'hD3);
    pulse_done(); pulse_done(); pulse_done(); pulse_done();
    repeat (10) @(negedge clk);
    e = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hD0, 8'hD1, 8'hD2, 8'hD3};
    chk_seq(e, "R7 byte stored same cycle");
  endtask

  task automatic t_overflow();
    logic [7:0] e[$];
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) send_byte(8'h60 + 8'(i));
    chk(overflow_o == 1'b0, "R8 two groups fit", overflow_o, 0);
    send_byte(8'hEE);
    chk(overflow_o == 1'b1, "R8 overflow raised", overflow_o, 1);
    send_byte(8'hEF); send_byte(8'hF0); send_byte(8'hF1);
    for (int i = 0; i < 8; i++) pulse_done();
    repeat (30) @(negedge clk);
    for (int i = 0; i < 8; i++) e.push_back(8'h60 + 8'(i));
    chk_seq(e, "R8 pending data intact");
    chk(overflow_o == 1'b1, "R8 overflow sticky", overflow_o, 1);
    send_byte(8'h71); send_byte(8'h72); send_byte(8'h73); send_byte(8'h74);
    for (int i = 0; i < 4; i++) pulse_done();
    repeat (10) @(negedge clk);
    e.push_back(8'h71); e.push_back(8'h72); e.push_back(8'h73); e.push_back(8'h74);
    chk_seq(e, "R8 accepted after drain");
  endtask

  task automatic t_idle_done();
    logic [7:0] e[$];
    bit seen;
    do_reset(1'b0);
    seen = 1'b0;
    tx_done_i = 1'b1;
    @(negedge clk);
    tx_done_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tx_start_o) seen = 1'b1;
    end
    chk(!seen, "R9 stray done starts nothing", seen, 0);
    auto_mode = 1'b1;
    send_byte(8'h81); send_byte(8'h82); send_byte(8'h83); send_byte(8'h84);
    repeat (60) @(negedge clk);
    e = '{8'h81, 8'h82, 8'h83, 8'h84};
    chk_seq(e, "R9 read position unmoved");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_partial();
    t_latency();
    t_burst();
    t_same_cycle();
    t_overflow();
    t_idle_done();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule